// File: doc/BRIEF.md
# Per-ID AXI Transaction Latency Monitor

This block watches an AXI port without driving it and measures how long each read and write transaction takes. A start timestamp is taken from a free-running cycle counter in the first cycle a request's VALID is high. It is kept in a small first-in first-out queue chosen by the transaction ID. When a response for that ID completes, the oldest queued timestamp of that ID is taken out and subtracted from the current counter value. Responses may return out of order across IDs but always in order within one ID, so one queue per ID pairs every response with its own request while many transactions are in flight.

For each direction the block keeps the most recent latency, the smallest and largest latency seen, the running sum and the number of timed transactions. A mean can be computed from the sum and the count. Measurement starts only after a cycle in which all four monitored VALIDs are low, so no transaction is already outstanding. Two sticky flags report problems: a response that finds its ID queue empty, and a request that finds its ID queue full. Data payloads are not observed.

Top module: `axi_lat_mon`

## Requirements
- R1: Read latency equals the counter value in the cycle where RVALID, RREADY and RLAST are all high, minus the counter value in the first cycle ARVALID was high for that request; beats without RLAST complete nothing.
- R2: Write latency equals the counter value in the first cycle BVALID is high for a response (stalled BREADY cycles do not move it), minus the counter value in the first cycle AWVALID was high for that request.
- R3: The start timestamp is taken once per request, in its first VALID cycle, even when READY stays low for several cycles; the request is queued when the handshake completes.
- R4: Within one ID, responses are paired with requests in issue order; responses of different IDs may return in any order and each is paired within its own ID.
- R5: Up to 8 requests per ID (queue depth parameter) may be outstanding at once and all are timed.
- R6: After reset `armed` is 0 and stays 0 until the first cycle in which ARVALID, RVALID, AWVALID and BVALID are all low; `armed` then reads 1 from the next cycle on. While `armed` is 0, requests and responses change no statistic and raise no flag.
- R7: A completing response (as defined in R1/R2) whose ID queue is empty while armed sets the sticky `resp_orphan` flag and changes no statistic.
- R8: A request handshake whose ID queue already holds 8 entries while armed sets the sticky `queue_overflow` flag and is not queued or timed.
- R9: After reset each count and sum is 0, each maximum is 0 and each minimum is all ones. Each timed transaction raises the count by one, adds its latency to the sum, and updates minimum, maximum and last-latency.
- R10: Every statistic is registered and shows a completing response one clock cycle after the cycle in which it completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts | input | TS_W | Free-running cycle counter used as time base |
| arvalid | input | 1 | Read address VALID |
| arready | input | 1 | Read address READY |
| arid | input | ID_W | Read address ID |
| rvalid | input | 1 | Read data VALID |
| rready | input | 1 | Read data READY |
| rid | input | ID_W | Read data ID |
| rlast | input | 1 | Last read beat marker |
| awvalid | input | 1 | Write address VALID |
| awready | input | 1 | Write address READY |
| awid | input | ID_W | Write address ID |
| bvalid | input | 1 | Write response VALID |
| bready | input | 1 | Write response READY |
| bid | input | ID_W | Write response ID |
| armed | output | 1 | Measurement enabled |
| resp_orphan | output | 1 | Sticky: response found an empty ID queue |
| queue_overflow | output | 1 | Sticky: request found a full ID queue |
| rd_last | output | TS_W | Most recent read latency |
| rd_min | output | TS_W | Smallest read latency |
| rd_max | output | TS_W | Largest read latency |
| rd_sum | output | SUM_W | Sum of read latencies |
| rd_cnt | output | CNT_W | Timed reads |
| wr_last | output | TS_W | Most recent write latency |
| wr_min | output | TS_W | Smallest write latency |
| wr_max | output | TS_W | Largest write latency |
| wr_sum | output | SUM_W | Sum of write latencies |
| wr_cnt | output | CNT_W | Timed writes |

## Verification
A corrupted queue pointer or count pairs a response with the wrong timestamp. That shows up on `rd_last`/`wr_last` one cycle after the response, because the bench gives each outstanding transaction of an ID a different latency. A queue that believes it is empty or full too early raises `resp_orphan` or `queue_overflow` one cycle after the offending handshake, where the bench expects the flag to stay low. A start timestamp taken again while READY is stalled, or at the wrong BVALID cycle, shifts the latency by the stall length on the very next update.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int unsigned LAT_Q_DEPTH_DEF = 8;

  // Modular elapsed time between two counter samples.
  function automatic logic [63:0] lat_elapsed(input logic [63:0] now_ts,
                                              input logic [63:0] start_ts);
    return now_ts - start_ts;
  endfunction
endpackage

// File: rtl/lat_start_capture.sv
module lat_start_capture #(
  parameter int TS_W = 32,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            valid,
  input  logic            ready,
  input  logic [ID_W-1:0] id,
  input  logic [TS_W-1:0] ts,
  output logic            push,
  output logic [ID_W-1:0] push_id,
  output logic [TS_W-1:0] push_ts
);
  logic            waiting;
  logic [TS_W-1:0] held_ts;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      held_ts <= '0;
    end else begin
      waiting <= valid & ~ready;
      if (valid && !waiting)
        held_ts <= ts;
    end
  end

  assign push    = en & valid & ready;
  assign push_id = id;
  assign push_ts = waiting ? held_ts : ts;
endmodule

// File: rtl/lat_id_queues.sv
module lat_id_queues #(
  parameter int ID_W  = 4,
  parameter int DEPTH = 8,
  parameter int TS_W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic [TS_W-1:0] push_ts,
  input  logic            pop,
  input  logic [ID_W-1:0] pop_id,
  output logic            push_drop,
  output logic            head_vld,
  output logic [TS_W-1:0] head_ts
);
  localparam int NQ = 1 << ID_W;
  localparam int PW = $clog2(DEPTH);
  localparam int AW = ID_W + PW;

  logic [TS_W-1:0] mem [NQ*DEPTH];
  logic [NQ-1:0]   full_v;
  logic [NQ-1:0]   nemp_v;
  logic [PW-1:0]   wp_all [NQ];
  logic [PW-1:0]   rp_all [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [PW-1:0] wp_q;
    logic [PW-1:0] rp_q;
    logic [PW:0]   cnt_q;
    logic          psh_q;
    logic          pop_q;

    assign psh_q = push && (push_id == ID_W'(q)) && !full_v[q];
    assign pop_q = pop && (pop_id == ID_W'(q)) && nemp_v[q];

    always_ff @(posedge clk) begin
      if (rst) begin
        wp_q  <= '0;
        rp_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (psh_q) wp_q <= wp_q + 1'b1;
        if (pop_q) rp_q <= rp_q + 1'b1;
        case ({psh_q, pop_q})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end

    assign full_v[q] = (cnt_q == (PW+1)'(DEPTH));
    assign nemp_v[q] = (cnt_q != '0);
    assign wp_all[q] = wp_q;
    assign rp_all[q] = rp_q;
  end

  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  assign wr_addr = {push_id, wp_all[push_id]};
  assign rd_addr = {pop_id, rp_all[pop_id]};

  always_ff @(posedge clk) begin
    if (push && !full_v[push_id])
      mem[wr_addr] <= push_ts;
  end

  assign head_ts   = mem[rd_addr];
  assign head_vld  = nemp_v[pop_id];
  assign push_drop = push & full_v[push_id];
endmodule

// File: rtl/lat_stats.sv
module lat_stats #(
  parameter int TS_W  = 32,
  parameter int CNT_W = 32,
  parameter int SUM_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [TS_W-1:0]  lat,
  output logic [TS_W-1:0]  last_lat,
  output logic [TS_W-1:0]  min_lat,
  output logic [TS_W-1:0]  max_lat,
  output logic [SUM_W-1:0] sum_lat,
  output logic [CNT_W-1:0] n_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      last_lat <= '0;
      min_lat  <= '1;
      max_lat  <= '0;
      sum_lat  <= '0;
      n_done   <= '0;
    end else if (upd) begin
      last_lat <= lat;
      if (lat < min_lat) min_lat <= lat;
      if (lat > max_lat) max_lat <= lat;
      sum_lat  <= sum_lat + SUM_W'(lat);
      n_done   <= n_done + 1'b1;
    end
  end
endmodule

// File: rtl/axi_lat_mon.sv
module axi_lat_mon #(
  parameter int ID_W    = 4,
  parameter int Q_DEPTH = lat_pkg::LAT_Q_DEPTH_DEF,
  parameter int TS_W    = 32,
  parameter int CNT_W   = 32,
  parameter int SUM_W   = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  ts,
  input  logic             arvalid,
  input  logic             arready,
  input  logic [ID_W-1:0]  arid,
  input  logic             rvalid,
  input  logic             rready,
  input  logic [ID_W-1:0]  rid,
  input  logic             rlast,
  input  logic             awvalid,
  input  logic             awready,
  input  logic [ID_W-1:0]  awid,
  input  logic             bvalid,
  input  logic             bready,
  input  logic [ID_W-1:0]  bid,
  output logic             armed,
  output logic             resp_orphan,
  output logic             queue_overflow,
  output logic [TS_W-1:0]  rd_last,
  output logic [TS_W-1:0]  rd_min,
  output logic [TS_W-1:0]  rd_max,
  output logic [SUM_W-1:0] rd_sum,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [TS_W-1:0]  wr_last,
  output logic [TS_W-1:0]  wr_min,
  output logic [TS_W-1:0]  wr_max,
  output logic [SUM_W-1:0] wr_sum,
  output logic [CNT_W-1:0] wr_cnt
);
  // Arm after the first fully idle cycle.
  logic bus_idle;
  assign bus_idle = ~(arvalid | rvalid | awvalid | bvalid);

  always_ff @(posedge clk) begin
    if (rst)                   armed <= 1'b0;
    else if (!armed && bus_idle) armed <= 1'b1;
  end

  // Request side: one capture per channel.
  logic            rq_push [2];
  logic [ID_W-1:0] rq_id   [2];
  logic [TS_W-1:0] rq_ts   [2];
  logic            ch_valid [2];
  logic            ch_ready [2];
  logic [ID_W-1:0] ch_id    [2];

  assign ch_valid[0] = arvalid;
  assign ch_ready[0] = arready;
  assign ch_id[0]    = arid;
  assign ch_valid[1] = awvalid;
  assign ch_ready[1] = awready;
  assign ch_id[1]    = awid;

  // Response side: read ends at last-beat handshake, write at first BVALID cycle.
  logic b_waiting;
  always_ff @(posedge clk) begin
    if (rst) b_waiting <= 1'b0;
    else     b_waiting <= bvalid & ~bready;
  end

  logic            rs_end [2];
  logic [ID_W-1:0] rs_id  [2];
  assign rs_end[0] = armed & rvalid & rready & rlast;
  assign rs_id[0]  = rid;
  assign rs_end[1] = armed & bvalid & ~b_waiting;
  assign rs_id[1]  = bid;

  logic            q_drop [2];
  logic            q_hvld [2];
  logic [TS_W-1:0] q_head [2];
  logic            st_upd [2];
  logic [TS_W-1:0] st_lat [2];

  logic [TS_W-1:0]  s_last [2];
  logic [TS_W-1:0]  s_min  [2];
  logic [TS_W-1:0]  s_max  [2];
  logic [SUM_W-1:0] s_sum  [2];
  logic [CNT_W-1:0] s_cnt  [2];

  for (genvar c = 0; c < 2; c++) begin : g_dir
    lat_start_capture #(.TS_W(TS_W), .ID_W(ID_W)) i_cap (
      .clk     (clk),
      .rst     (rst),
      .en      (armed),
      .valid   (ch_valid[c]),
      .ready   (ch_ready[c]),
      .id      (ch_id[c]),
      .ts      (ts),
      .push    (rq_push[c]),
      .push_id (rq_id[c]),
      .push_ts (rq_ts[c])
    );

    lat_id_queues #(.ID_W(ID_W), .DEPTH(Q_DEPTH), .TS_W(TS_W)) i_q (
      .clk       (clk),
      .rst       (rst),
      .push      (rq_push[c]),
      .push_id   (rq_id[c]),
      .push_ts   (rq_ts[c]),
      .pop       (rs_end[c]),
      .pop_id    (rs_id[c]),
      .push_drop (q_drop[c]),
      .head_vld  (q_hvld[c]),
      .head_ts   (q_head[c])
    );

    assign st_upd[c] = rs_end[c] & q_hvld[c];
    assign st_lat[c] = TS_W'(lat_pkg::lat_elapsed(64'(ts), 64'(q_head[c])));

    lat_stats #(.TS_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) i_st (
      .clk      (clk),
      .rst      (rst),
      .upd      (st_upd[c]),
      .lat      (st_lat[c]),
      .last_lat (s_last[c]),
      .min_lat  (s_min[c]),
      .max_lat  (s_max[c]),
      .sum_lat  (s_sum[c]),
      .n_done   (s_cnt[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_orphan    <= 1'b0;
      queue_overflow <= 1'b0;
    end else begin
      if ((rs_end[0] && !q_hvld[0]) || (rs_end[1] && !q_hvld[1]))
        resp_orphan <= 1'b1;
      if (q_drop[0] || q_drop[1])
        queue_overflow <= 1'b1;
    end
  end

  assign rd_last = s_last[0];
  assign rd_min  = s_min[0];
  assign rd_max  = s_max[0];
  assign rd_sum  = s_sum[0];
  assign rd_cnt  = s_cnt[0];
  assign wr_last = s_last[1];
  assign wr_min  = s_min[1];
  assign wr_max  = s_max[1];
  assign wr_sum  = s_sum[1];
  assign wr_cnt  = s_cnt[1];
endmodule

// File: rtl/lat_mon_chk.sv
module lat_mon_chk #(
  parameter int TS_W  = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             rvalid,
  input logic             rready,
  input logic             rlast,
  input logic             bvalid,
  input logic             armed,
  input logic             resp_orphan,
  input logic             queue_overflow,
  input logic [TS_W-1:0]  rd_last,
  input logic [TS_W-1:0]  rd_min,
  input logic [TS_W-1:0]  rd_max,
  input logic [CNT_W-1:0] rd_cnt,
  input logic [TS_W-1:0]  wr_min,
  input logic [TS_W-1:0]  wr_max,
  input logic [CNT_W-1:0] wr_cnt
);
  // R6
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> ($stable(rd_cnt) && $stable(wr_cnt)));

  // R7
  orphan_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    resp_orphan |=> resp_orphan);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    queue_overflow |=> queue_overflow);

  // R1
  rd_done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_cnt) |-> $past(rvalid && rready && rlast));

  // R2
  wr_done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_cnt) |-> $past(bvalid));

  // R9
  rd_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_cnt) |-> (rd_cnt == $past(rd_cnt) + 1'b1));

  // R9
  rd_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_cnt != '0) |-> (rd_min <= rd_last && rd_last <= rd_max));

  // R9
  wr_order_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt != '0) |-> (wr_min <= wr_max));
endmodule

bind axi_lat_mon lat_mon_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_axi_lat_mon.sv
module test_axi_lat_mon;
  localparam int ID_W = 4;
  localparam int TS_W = 32;
  localparam int CNT_W = 32;
  localparam int SUM_W = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TS_W-1:0] ts = '0;
  logic arvalid = 0, arready = 0, rvalid = 0, rready = 0, rlast = 0;
  logic awvalid = 0, awready = 0, bvalid = 0, bready = 0;
  logic [ID_W-1:0] arid = '0, rid = '0, awid = '0, bid = '0;
  logic armed, resp_orphan, queue_overflow;
  logic [TS_W-1:0] rd_last, rd_min, rd_max, wr_last, wr_min, wr_max;
  logic [SUM_W-1:0] rd_sum, wr_sum;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;

  always #2 clk = ~clk;
  always @(posedge clk) ts <= ts + 1;

  axi_lat_mon #(.ID_W(ID_W), .TS_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) i_axi_lat_mon (
    .clk(clk), .rst(rst), .ts(ts),
    .arvalid(arvalid), .arready(arready), .arid(arid),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rlast(rlast),
    .awvalid(awvalid), .awready(awready), .awid(awid),
    .bvalid(bvalid), .bready(bready), .bid(bid),
    .armed(armed), .resp_orphan(resp_orphan), .queue_overflow(queue_overflow),
    .rd_last(rd_last), .rd_min(rd_min), .rd_max(rd_max), .rd_sum(rd_sum), .rd_cnt(rd_cnt),
    .wr_last(wr_last), .wr_min(wr_min), .wr_max(wr_max), .wr_sum(wr_sum), .wr_cnt(wr_cnt)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard state
  logic [TS_W-1:0] rd_start [16][$];
  logic [TS_W-1:0] wr_start [16][$];
  logic [TS_W-1:0] exp_rd [$];
  logic [TS_W-1:0] exp_wr [$];

  task automatic rd_req(input int id, input int stall);
    @(negedge clk);
    arvalid = 1; arid = ID_W'(id); arready = 0;
    rd_start[id].push_back(ts);
    repeat (stall) @(negedge clk);
    arready = 1;
    @(negedge clk);
    arvalid = 0; arready = 0;
  endtask

  task automatic rd_resp(input int id, input int beats);
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      rvalid = 1; rready = 1; rid = ID_W'(id); rlast = (b == beats - 1);
      if (b == beats - 1) exp_rd.push_back(ts - rd_start[id].pop_front());
    end
    @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
  endtask

  task automatic wr_req(input int id, input int stall, input bit timed);
    @(negedge clk);
    awvalid = 1; awid = ID_W'(id); awready = 0;
    if (timed) wr_start[id].push_back(ts);
    repeat (stall) @(negedge clk);
    awready = 1;
    @(negedge clk);
    awvalid = 0; awready = 0;
  endtask

  task automatic wr_resp(input int id, input int stall);
    @(negedge clk);
    bvalid = 1; bid = ID_W'(id); bready = (stall == 0);
    exp_wr.push_back(ts - wr_start[id].pop_front());
    repeat (stall) @(negedge clk);
    bready = 1;
    @(negedge clk);
    bvalid = 0; bready = 0;
  endtask

  // Monitor: pops expected latencies as the design reports completions (R10)
  logic [CNT_W-1:0] prev_rd = '0, prev_wr = '0;
  logic [TS_W-1:0]  m_rmin = '1, m_rmax = '0, m_wmin = '1, m_wmax = '0;
  logic [SUM_W-1:0] m_rsum = '0, m_wsum = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_cnt != prev_rd) begin
        if (exp_rd.size() == 0) chk(0, "R7", "unexpected read completion", 64'(rd_cnt), 64'(prev_rd));
        else begin
          logic [TS_W-1:0] e;
          e = exp_rd.pop_front();
          if (e < m_rmin) m_rmin = e;
          if (e > m_rmax) m_rmax = e;
          m_rsum = m_rsum + SUM_W'(e);
          chk(rd_last == e, "R1 R4", "read latency", 64'(rd_last), 64'(e));
          chk(rd_cnt == prev_rd + 1, "R9", "read count", 64'(rd_cnt), 64'(prev_rd + 1));
          chk(rd_min == m_rmin && rd_max == m_rmax, "R9", "read min/max", 64'(rd_max), 64'(m_rmax));
          chk(rd_sum == m_rsum, "R9", "read sum", 64'(rd_sum), 64'(m_rsum));
        end
        prev_rd = rd_cnt;
      end
      if (wr_cnt != prev_wr) begin
        if (exp_wr.size() == 0) chk(0, "R7", "unexpected write completion", 64'(wr_cnt), 64'(prev_wr));
        else begin
          logic [TS_W-1:0] e;
          e = exp_wr.pop_front();
          if (e < m_wmin) m_wmin = e;
          if (e > m_wmax) m_wmax = e;
          m_wsum = m_wsum + SUM_W'(e);
          chk(wr_last == e, "R2 R4", "write latency", 64'(wr_last), 64'(e));
          chk(wr_min == m_wmin && wr_max == m_wmax, "R9", "write min/max", 64'(wr_min), 64'(m_wmin));
          chk(wr_sum == m_wsum, "R9", "write sum", 64'(wr_sum), 64'(m_wsum));
        end
        prev_wr = wr_cnt;
      end
    end
  end

  initial begin
    // R6: request and last beat held active across reset release
    arvalid = 1; rvalid = 1; rready = 1; rlast = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(armed == 0, "R6", "armed while busy", 64'(armed), 0);
    chk(rd_cnt == 0 && resp_orphan == 0, "R6", "unarmed activity counted", 64'(rd_cnt), 0);
    chk(rd_min == '1 && rd_max == 0 && rd_sum == 0, "R9", "reset min/max/sum", 64'(rd_min), 64'(32'hFFFF_FFFF));
    arvalid = 0; rvalid = 0; rready = 0; rlast = 0;
    @(negedge clk);
    chk(armed == 1, "R6", "armed after idle", 64'(armed), 1);

    // R1 R3: stalled AR, multi-beat read
    rd_req(3, 3);
    repeat (4) @(negedge clk);
    rd_resp(3, 2);

    // R4 R5: several outstanding, out of order across IDs
    rd_req(1, 0);
    rd_req(1, 1);
    rd_req(1, 0);
    rd_req(2, 2);
    repeat (2) @(negedge clk);
    rd_resp(2, 1);
    rd_resp(1, 3);
    rd_resp(1, 1);
    repeat (3) @(negedge clk);
    rd_resp(1, 2);

    // R2 R3: stalled AW, stalled BREADY
    wr_req(4, 2, 1);
    wr_req(6, 0, 1);
    repeat (3) @(negedge clk);
    wr_resp(6, 3);
    wr_resp(4, 0);

    repeat (3) @(negedge clk);
    chk(resp_orphan == 0 && queue_overflow == 0, "R7 R8", "flags before error cases",
        64'({resp_orphan, queue_overflow}), 0);

    // R7: response with no outstanding request
    @(negedge clk);
    bvalid = 1; bid = 4'd9; bready = 1;
    @(negedge clk);
    bvalid = 0; bready = 0;
    @(negedge clk);
    chk(resp_orphan == 1, "R7", "orphan flag", 64'(resp_orphan), 1);
    chk(wr_cnt == 2, "R7", "orphan changed write count", 64'(wr_cnt), 2);

    // R8 R5: fill ID 5 with 8, ninth dropped
    for (int i = 0; i < 8; i++) wr_req(5, i % 2, 1);
    @(negedge clk);
    chk(queue_overflow == 0, "R5", "overflow at depth 8", 64'(queue_overflow), 0);
    wr_req(5, 0, 0);
    @(negedge clk);
    chk(queue_overflow == 1, "R8", "overflow flag", 64'(queue_overflow), 1);
    for (int i = 0; i < 8; i++) begin
      wr_resp(5, i % 3);
      repeat (i) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(wr_cnt == 10, "R8", "write count after overflow", 64'(wr_cnt), 10);
    chk(rd_cnt == 5, "R4", "read count", 64'(rd_cnt), 5);
    chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R10", "pending expected items",
        64'(exp_rd.size() + exp_wr.size()), 0);
    chk(queue_overflow == 1 && resp_orphan == 1, "R7 R8", "sticky flags",
        64'({resp_orphan, queue_overflow}), 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule